// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps track of the frames sitting in a receive buffer and shows the host one 16-bit status word for the oldest of them. The MAC side sends one pulse for each byte written into the buffer and an end pulse that carries a raw 4-bit error class. The block turns these into a queue entry holding a normalised error code and a clamped byte count. The byte storage itself lives elsewhere.

The host reads the status word and reads packet data in fixed-size units. It retires the oldest frame with a discard command. A receive-reset command flushes everything. Two diagnostic flags are raised:
- a status-overrun flag while the queue is full, during which new frames are refused;
- a sticky underrun flag, also driven out as an adapter-failure indication, when the host reads beyond the data that has arrived.

Top module: `rx_pkt_status_queue`

## Requirements
- R1: After the synchronous reset `rst`, the status word is 0x8000, and `receiving`, `status_overrun`, `rd_underrun` and `adapter_fail` are all low.
- R2: A completed frame is appended to the queue. While the queue holds at least one frame, the status word is {bit15=0, bits14..11=code, bits10..0=byte count} of the oldest frame, and frames are reported in arrival order.
- R3: Bit 15 is 1 exactly when the queue is empty. In that state bits 14..11 are 0, and bits 10..0 give the bytes of the frame currently arriving, or 0 if no frame is arriving.
- R4: The raw error class is kept when it is one of 1000 (overrun), 1011 (runt), 1100 (alignment), 1101 (CRC), 1001 (oversize) or 0010 (dribble). Any other value is stored as 0000 (no error).
- R5: A frame of more than MAX_FRAME (1514) bytes is stored with code 1001, whatever its raw class, and with a byte count of 1514. A partial count never shows more than 1514.
- R6: `host_discard` removes the oldest frame at the next clock edge. A discard while the queue is empty has no effect.
- R7: `status_overrun` is high while DEPTH (8) frames are held. While it is high, a byte that would start a new frame is ignored, and an end pulse drops the frame. The flag falls once a frame is discarded, and the next frame is then accepted. Fullness is judged at the start of the cycle, so a discard in the same cycle does not admit an end pulse.
- R8: `receiving` rises after the first accepted byte of a frame and falls after the end pulse of that frame.
- R9: Each `host_read` consumes RD_UNIT (2) bytes of the oldest frame. If the queue is empty, the read is taken from the arriving frame. A read that would pass the bytes available sets `rd_underrun` and `adapter_fail`, and both stay set through discards.
- R10: `host_rx_reset` has the same effect as `rst`: it empties the queue, aborts an arriving frame, and clears every flag and the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| mac_byte | input | 1 | One byte written into the receive buffer |
| mac_end | input | 1 | Frame end (may coincide with its last byte) |
| mac_err | input | 4 | Raw error class of the ending frame |
| host_discard | input | 1 | Retire the oldest frame |
| host_rx_reset | input | 1 | Flush queue and clear flags |
| host_read | input | 1 | Host reads one unit of packet data |
| status_word | output | 16 | Status of the oldest frame |
| receiving | output | 1 | A frame is arriving |
| status_overrun | output | 1 | Queue full, new frames refused |
| rd_underrun | output | 1 | Host read past the available data (sticky) |
| adapter_fail | output | 1 | Failure indication raised by the underrun |

## Verification
Every input is sampled at a rising edge, and its effect is visible on all outputs just after that same edge. The status word and flags are decoded from registers, with no further stage. The bench drives stimulus after a falling edge and waits for one rising edge. It updates its reference model for that edge and then compares every output at the next falling edge, away from any edge where the design changes. Directed cases check the full queue, oversized frames, the read boundary and resets mid-frame against hand-derived words. The same per-cycle comparison covers the random traffic.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int STAT_W = 16;
    localparam int LEN_W  = 11;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        RX_ERR_NONE     = 4'b0000,
        RX_ERR_DRIBBLE  = 4'b0010,
        RX_ERR_OVERRUN  = 4'b1000,
        RX_ERR_OVERSIZE = 4'b1001,
        RX_ERR_RUNT     = 4'b1011,
        RX_ERR_ALIGN    = 4'b1100,
        RX_ERR_CRC      = 4'b1101
    } rx_err_e;

    typedef struct packed {
        rx_err_e            code;
        logic [LEN_W-1:0]   len;
    } rx_entry_t;

    // Normalise a raw error class; an oversized frame overrides it.
    function automatic rx_err_e map_err(input logic [CODE_W-1:0] raw,
                                        input logic oversize);
        rx_err_e r;
        if (oversize) begin
            r = RX_ERR_OVERSIZE;
        end else begin
            case (raw)
                4'b1000: r = RX_ERR_OVERRUN;
                4'b1001: r = RX_ERR_OVERSIZE;
                4'b1011: r = RX_ERR_RUNT;
                4'b1100: r = RX_ERR_ALIGN;
                4'b1101: r = RX_ERR_CRC;
                4'b0010: r = RX_ERR_DRIBBLE;
                default: r = RX_ERR_NONE;
            endcase
        end
        return r;
    endfunction

    // Build the host-visible word from the queue head or the arriving frame.
    function automatic logic [STAT_W-1:0] pack_status(input logic empty,
                                                      input rx_entry_t head,
                                                      input logic [LEN_W-1:0] partial);
        logic [STAT_W-1:0] w;
        if (empty) w = {1'b1, {CODE_W{1'b0}}, partial};
        else       w = {1'b0, head};
        return w;
    endfunction

endpackage

// File: rtl/rxq_frame_acc.sv
module rxq_frame_acc
    import rxq_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int MAX_FRAME = 1514
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               byte_in,
    input  logic               end_in,
    input  logic [CODE_W-1:0]  err_in,
    input  logic               full,
    output logic               receiving,
    output logic [LEN_W-1:0]   partial_len,
    output logic               push,
    output rx_entry_t          push_entry
);

    localparam logic [CNT_W-1:0] CNT_TOP   = '1;
    localparam logic [CNT_W-1:0] FRAME_LIM = CNT_W'(MAX_FRAME);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             active_q;
    logic             take_byte;
    logic             oversize;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [CNT_W-1:0] v);
        logic [LEN_W-1:0] r;
        if (v > FRAME_LIM) r = LEN_W'(MAX_FRAME);
        else               r = v[LEN_W-1:0];
        return r;
    endfunction

    always_comb begin
        take_byte = byte_in && (active_q || !full);
        cnt_nx    = cnt_q;
        if (take_byte && cnt_q != CNT_TOP) cnt_nx = cnt_q + 1'b1;
        oversize        = cnt_nx > FRAME_LIM;
        push            = end_in && !full;
        push_entry.code = map_err(err_in, oversize);
        push_entry.len  = clamp_len(cnt_nx);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (end_in) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (take_byte) begin
            cnt_q    <= cnt_nx;
            active_q <= 1'b1;
        end
    end

    assign receiving   = active_q;
    assign partial_len = clamp_len(cnt_q);

endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        clr,
    input  logic                        push,
    input  rx_entry_t                   push_entry,
    input  logic                        pop,
    output rx_entry_t                   head,
    output logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        full,
    output logic                        empty,
    output logic                        pop_done
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH+1);

    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CW-1:0]    count_q;
    logic             do_push;
    logic             do_pop;
    rx_entry_t        cell_vec [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        logic [PTR_W-1:0] r;
        if (p == PTR_W'(DEPTH-1)) r = '0;
        else                      r = p + 1'b1;
        return r;
    endfunction

    assign full     = count_q == CW'(DEPTH);
    assign empty    = count_q == '0;
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_done = do_pop;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        rx_entry_t cell_q;
        always_ff @(posedge clk) begin
            if (do_push && wr_ptr_q == PTR_W'(g)) cell_q <= push_entry;
        end
        assign cell_vec[g] = cell_q;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head  = cell_vec[rd_ptr_q];
    assign count = count_q;

endmodule

// File: rtl/rxq_read_guard.sv
module rxq_read_guard
    import rxq_pkg::*;
#(
    parameter int RD_UNIT = 2
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              rd,
    input  logic              pop,
    input  logic [LEN_W-1:0]  readable,
    output logic              underrun
);

    localparam int PW = LEN_W + 1;

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_step;
    logic          past_end;
    logic          unr_q;

    assign ptr_step = ptr_q + PW'(RD_UNIT);
    assign past_end = ptr_step > {1'b0, readable};

    always_ff @(posedge clk) begin
        if (clr) begin
            ptr_q <= '0;
            unr_q <= 1'b0;
        end else begin
            if (rd && past_end) unr_q <= 1'b1;
            if (pop)                    ptr_q <= '0;
            else if (rd && !past_end)   ptr_q <= ptr_step;
        end
    end

    assign underrun = unr_q;

endmodule

// File: rtl/rx_pkt_status_queue.sv
module rx_pkt_status_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int MAX_FRAME = 1514,
    parameter int CNT_W     = 12,
    parameter int RD_UNIT   = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mac_byte,
    input  logic         mac_end,
    input  logic [3:0]   mac_err,
    input  logic         host_discard,
    input  logic         host_rx_reset,
    input  logic         host_read,
    output logic [15:0]  status_word,
    output logic         receiving,
    output logic         status_overrun,
    output logic         rd_underrun,
    output logic         adapter_fail
);

    localparam int FC_W = $clog2(DEPTH+1);

    logic              clr;
    logic              q_full;
    logic              q_empty;
    logic              q_pop_done;
    logic              acc_push;
    rx_entry_t         acc_entry;
    rx_entry_t         q_head;
    logic [LEN_W-1:0]  acc_partial;
    logic [LEN_W-1:0]  readable;
    logic [FC_W-1:0]   fifo_count;
    logic              unr;

    assign clr = rst || host_rx_reset;

    rxq_frame_acc #(
        .CNT_W     (CNT_W),
        .MAX_FRAME (MAX_FRAME)
    ) u_acc (
        .clk         (clk),
        .clr         (clr),
        .byte_in     (mac_byte),
        .end_in      (mac_end),
        .err_in      (mac_err),
        .full        (q_full),
        .receiving   (receiving),
        .partial_len (acc_partial),
        .push        (acc_push),
        .push_entry  (acc_entry)
    );

    rxq_status_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk        (clk),
        .clr        (clr),
        .push       (acc_push),
        .push_entry (acc_entry),
        .pop        (host_discard),
        .head       (q_head),
        .count      (fifo_count),
        .full       (q_full),
        .empty      (q_empty),
        .pop_done   (q_pop_done)
    );

    assign readable = q_empty ? acc_partial : q_head.len;

    rxq_read_guard #(
        .RD_UNIT (RD_UNIT)
    ) u_guard (
        .clk      (clk),
        .clr      (clr),
        .rd       (host_read),
        .pop      (q_pop_done),
        .readable (readable),
        .underrun (unr)
    );

    assign status_word    = pack_status(q_empty, q_head, acc_partial);
    assign status_overrun = q_full;
    assign rd_underrun    = unr;
    assign adapter_fail   = unr;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH     = 8,
    parameter int MAX_FRAME = 1514
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        mac_end,
    input logic                        host_discard,
    input logic                        host_rx_reset,
    input logic [15:0]                 status_word,
    input logic                        receiving,
    input logic                        status_overrun,
    input logic                        rd_underrun,
    input logic [$clog2(DEPTH+1)-1:0]  fifo_count
);

    localparam int CW = $clog2(DEPTH+1);

    // R6
    discard_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (host_discard && fifo_count != '0 && !mac_end && !host_rx_reset)
        |=> fifo_count == $past(fifo_count) - 1'b1);

    // R10
    rx_reset_chk: assert property (@(posedge clk) disable iff (rst)
        host_rx_reset |=> (fifo_count == '0 && !receiving && !rd_underrun
                           && status_word == 16'h8000));

    // R9
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_underrun && !host_rx_reset) |=> rd_underrun);

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (status_overrun && !host_discard && !host_rx_reset) |=> status_overrun);

    // R7
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    // R3
    empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
        status_word[15] == (fifo_count == '0));

    // R5
    len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        status_word[10:0] <= 11'(MAX_FRAME));

    // R8
    recv_end_chk: assert property (@(posedge clk) disable iff (rst)
        mac_end |=> !receiving);

endmodule

bind rx_pkt_status_queue rxq_checker #(
    .DEPTH     (DEPTH),
    .MAX_FRAME (MAX_FRAME)
) u_rxq_chk (
    .clk            (clk),
    .rst            (rst),
    .mac_end        (mac_end),
    .host_discard   (host_discard),
    .host_rx_reset  (host_rx_reset),
    .status_word    (status_word),
    .receiving      (receiving),
    .status_overrun (status_overrun),
    .rd_underrun    (rd_underrun),
    .fifo_count     (fifo_count)
);

// File: tb/rx_pkt_status_queue_bench.sv
`timescale 1ns/1ps
module rx_pkt_status_queue_bench;

    localparam int DEPTH   = 8;
    localparam int MAXF    = 1514;
    localparam int RD_UNIT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mac_byte = 1'b0;
    logic        mac_end = 1'b0;
    logic [3:0]  mac_err = 4'b0;
    logic        host_discard = 1'b0;
    logic        host_rx_reset = 1'b0;
    logic        host_read = 1'b0;
    logic [15:0] status_word;
    logic        receiving;
    logic        status_overrun;
    logic        rd_underrun;
    logic        adapter_fail;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int m_len [DEPTH];
    int m_code [DEPTH];
    int m_n = 0;
    int m_cnt = 0;
    bit m_active = 1'b0;
    int m_rdptr = 0;
    bit m_unr = 1'b0;

    always #4 clk = ~clk;

    rx_pkt_status_queue u_rx_pkt_status_queue (
        .clk            (clk),
        .rst            (rst),
        .mac_byte       (mac_byte),
        .mac_end        (mac_end),
        .mac_err        (mac_err),
        .host_discard   (host_discard),
        .host_rx_reset  (host_rx_reset),
        .host_read      (host_read),
        .status_word    (status_word),
        .receiving      (receiving),
        .status_overrun (status_overrun),
        .rd_underrun    (rd_underrun),
        .adapter_fail   (adapter_fail)
    );

    function automatic int cap(input int v);
        return (v > MAXF) ? MAXF : v;
    endfunction

    function automatic int exp_code(input int raw, input bit ovs);
        if (ovs) return 9;
        case (raw)
            8, 9, 11, 12, 13, 2: return raw;
            default:             return 0;
        endcase
    endfunction

    function automatic logic [15:0] word_of(input int code, input int len);
        return {1'b0, 4'(code), 11'(len)};
    endfunction

    function automatic logic [15:0] model_word();
        if (m_n == 0) return {1'b1, 4'b0000, 11'(cap(m_cnt))};
        return word_of(m_code[0], m_len[0]);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit b, input bit e, input int er, input bit d,
                              input bit x, input bit r, input bit g);
        bit full;
        int readable;
        bit pop;
        bit take;
        int cntn;
        if (g || x) begin
            m_n = 0; m_cnt = 0; m_active = 0; m_rdptr = 0; m_unr = 0;
            return;
        end
        full     = (m_n == DEPTH);
        readable = (m_n == 0) ? cap(m_cnt) : m_len[0];
        pop      = d && (m_n != 0);
        if (r) begin
            if (m_rdptr + RD_UNIT > readable) m_unr = 1;
            else m_rdptr = m_rdptr + RD_UNIT;
        end
        if (pop) begin
            m_rdptr = 0;
            for (int i = 0; i < DEPTH - 1; i++) begin
                m_len[i]  = m_len[i+1];
                m_code[i] = m_code[i+1];
            end
            m_n--;
        end
        take = b && (m_active || !full);
        cntn = m_cnt + (take ? 1 : 0);
        if (cntn > 4095) cntn = 4095;
        if (e) begin
            if (!full) begin
                m_len[m_n]  = cap(cntn);
                m_code[m_n] = exp_code(er, cntn > MAXF);
                m_n++;
            end
            m_cnt = 0; m_active = 0;
        end else if (take) begin
            m_cnt = cntn; m_active = 1;
        end
    endtask

    task automatic compare_all();
        chk((m_n == 0) ? "R3 status" : "R2 status", status_word, model_word());
        chk("R8 receiving", receiving, m_active);
        chk("R7 status_overrun", status_overrun, m_n == DEPTH);
        chk("R9 rd_underrun", rd_underrun, m_unr);
        chk("R9 adapter_fail", adapter_fail, m_unr);
    endtask

    // one cycle: drive after falling edge, model the rising edge, compare at next falling edge
    task automatic step(input bit b, input bit e, input int er, input bit d,
                        input bit x, input bit r, input bit g);
        mac_byte = b; mac_end = e; mac_err = 4'(er);
        host_discard = d; host_rx_reset = x; host_read = r; rst = g;
        @(posedge clk);
        model_edge(b, e, er, d, x, r, g);
        @(negedge clk);
        mac_byte = 0; mac_end = 0; host_discard = 0; host_rx_reset = 0;
        host_read = 0; rst = 0;
        compare_all();
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic send_pkt(input int n, input int er);
        for (int i = 0; i < n - 1; i++) step(1, 0, 0, 0, 0, 0, 0);
        step(n > 0, 1, er, 0, 0, 0, 0);
    endtask

    task automatic discard();
        step(0, 0, 0, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 1);
        // R1 reset state
        chk("R1 status after reset", status_word, 16'h8000);
        chk("R1 flags after reset", {receiving, status_overrun, rd_underrun, adapter_fail}, 0);

        // R8 receiving after first byte; R3 partial count shown
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R8 receiving after first byte", receiving, 1);
        chk("R3 partial count", status_word, 16'h8001);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0);
        step(1, 1, 13, 0, 0, 0, 0);
        // R4 CRC code kept, R2 head word
        chk("R4 crc entry", status_word, word_of(13, 5));
        chk("R8 receiving after end", receiving, 0);

        send_pkt(3, 5);
        chk("R2 oldest still at head", status_word, word_of(13, 5));
        discard();
        chk("R4 unknown code maps to none", status_word, word_of(0, 3));
        discard();
        chk("R6 empty after discards", status_word, 16'h8000);
        discard();
        chk("R6 discard on empty", status_word, 16'h8000);

        // R4 each listed code
        send_pkt(2, 8);  send_pkt(2, 11); send_pkt(2, 12); send_pkt(2, 2);
        chk("R4 overrun code", status_word, word_of(8, 2));
        discard(); chk("R4 runt code", status_word, word_of(11, 2));
        discard(); chk("R4 alignment code", status_word, word_of(12, 2));
        discard(); chk("R4 dribble code", status_word, word_of(2, 2));
        discard();

        // R5 oversize frame
        for (int i = 0; i < 1519; i++) step(1, 0, 0, 0, 0, 0, 0);
        chk("R5 partial capped", status_word, {1'b1, 4'b0, 11'(MAXF)});
        step(1, 1, 13, 0, 0, 0, 0);
        chk("R5 oversize entry", status_word, word_of(9, MAXF));
        discard();

        // R9 underrun
        send_pkt(3, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R9 read within frame", rd_underrun, 0);
        step(0, 0, 0, 0, 0, 1, 0);
        chk("R9 read past end", rd_underrun, 1);
        chk("R9 adapter fail", adapter_fail, 1);
        discard();
        chk("R9 sticky through discard", rd_underrun, 1);
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R10 rx reset clears underrun", rd_underrun, 0);

        // R7 full queue
        for (int k = 1; k <= DEPTH; k++) send_pkt(k, 0);
        chk("R7 overrun flag when full", status_overrun, 1);
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R7 byte ignored while full", receiving, 0);
        send_pkt(9, 13);
        chk("R7 frame dropped while full", status_word, word_of(0, 1));
        step(0, 1, 0, 1, 0, 0, 0);
        chk("R7 end with same-cycle discard dropped", status_word, word_of(0, 2));
        chk("R7 flag clears after discard", status_overrun, 0);
        send_pkt(20, 12);
        chk("R7 accepted after room", status_overrun, 1);
        for (int k = 0; k < DEPTH - 1; k++) discard();
        chk("R7 late frame at head", status_word, word_of(12, 20));
        discard();

        // R10 reset mid-frame
        send_pkt(4, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0);
        chk("R10 queue flushed", status_word, 16'h8000);
        chk("R10 arriving frame aborted", receiving, 0);

        // random traffic
        for (int c = 0; c < 6000; c++) begin
            bit b, e, d, x, r, g;
            b = ($urandom % 10) < 6;
            e = ($urandom % 10) == 0;
            d = ($urandom % 9) == 0;
            x = ($urandom % 400) == 0;
            r = ($urandom % 6) == 0;
            g = ($urandom % 900) == 0;
            step(b, e, int'($urandom % 16), d, x, r, g);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule